// File: doc/BRIEF.md
# External Bus Request and Parking Controller

This block sits between a processor's access sequencer and an external bus arbiter. It drives an active-low request line toward the arbiter and keeps a master/slave status flag that the access sequencer uses to decide whether an external transfer may start. Several internal sources can ask for an external transfer at once. Their requests are combined into one request line. A software hold bit can keep that line asserted when no transfer is pending.

Mastership is gained when the arbiter's grant is present, the bus is reported free and the block wants the bus. It is given up when the grant is withdrawn. It is also given up when the block stops wanting the bus, unless parking is enabled. When parking is enabled the block stays master with its request released. A later access then runs at once, without a new arbitration round. The grant and bus-free inputs can pass through a parameterised synchronizer (`SYNC_STAGES`, default 0) when the arbiter runs on another clock. Each stage adds one cycle to every grant-related response.

Top module: `extbus_req_ctl`

## Requirements
- R1: While `rst_n` is low, `breq_n` is 1 and `is_master` is 0.
- R2: `breq_n` is low in the cycle after any bit of `ext_req` or `req_hold` is high. It is high in the cycle after all of them are low. This holds whether the block is master or slave.
- R3: `breq_n` is always driven to a defined 0 or 1 and is never high-impedance or unknown.
- R4: `req_hold` high keeps `breq_n` low with `ext_req` all zero. It also lets the block take mastership.
- R5: `is_master` stays 0 while `bus_grant` is low.
- R6: A slave becomes master one cycle after a clock edge at which `bus_grant`=1, `bus_free`=1 and the bus is wanted (any `ext_req` bit or `req_hold`).
- R7: A slave that sees `bus_grant`=1 while `bus_free`=0 stays slave.
- R8: A master that no longer wants the bus, with `park_en`=0 and grant held, becomes slave on the next cycle.
- R9: A master that no longer wants the bus, with `park_en`=1 and grant held, stays master (parked) while `breq_n` is high.
- R10: A new access started while parked keeps `is_master` at 1 with no slave cycle, whatever the state of `bus_free`. `breq_n` goes low again per R2.
- R11: Removal of `bus_grant` makes a master a slave on the next cycle, whether it is parked or mid-access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ext_req | input | NUM_EXT | One request bit per internal source needing an external transfer |
| req_hold | input | 1 | Software bit forcing the request line active |
| bus_grant | input | 1 | Grant from the external arbiter, active high |
| bus_free | input | 1 | High when no other master is driving the bus |
| park_en | input | 1 | Allows mastership to be kept after the request drops |
| breq_n | output | 1 | Active-low bus request toward the arbiter, always driven |
| is_master | output | 1 | 1 while this block owns the external bus |

## Verification
With the default of zero synchronizer stages, both `breq_n` and `is_master` respond exactly one clock after the input pattern that causes the change. The bench changes inputs on the falling edge. For each applied pattern it queues the expected pair of outputs. A monitor compares that pair shortly after the next rising edge, so every result is checked in the one cycle it is due and not earlier. The reset values are checked while reset is still held.

// File: rtl/extbus_req_pkg.sv
package extbus_req_pkg;

   typedef enum logic {
      TEN_SLAVE  = 1'b0,
      TEN_MASTER = 1'b1
   } tenure_e;

   localparam int unsigned MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/extbus_want_reg.sv
module extbus_want_reg #(
   parameter int unsigned NUM_EXT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_req,
   input  logic               req_hold,
   output logic               want,
   output logic               breq_n
);

   logic any_ext;

   assign any_ext = |ext_req;
   assign want    = any_ext | req_hold;

   // registered, never released to high impedance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         breq_n <= 1'b1;
      end else begin
         breq_n <= ~want;
      end
   end

endmodule

// File: rtl/extbus_in_sync.sv
module extbus_in_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   generate
      if (STAGES == 0) begin : g_direct
         assign d_out = d_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q[0] <= d_in;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], d_in};
            end
         end
         assign d_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/extbus_tenure_fsm.sv
module extbus_tenure_fsm
   import extbus_req_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic gnt,
   input  logic free,
   input  logic park_en,
   output logic is_master
);

   tenure_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         TEN_SLAVE: begin
            if (gnt && free && want) begin
               state_d = TEN_MASTER;
            end
         end
         TEN_MASTER: begin
            if (!gnt) begin
               state_d = TEN_SLAVE;
            end else if (want || park_en) begin
               state_d = TEN_MASTER;
            end else begin
               state_d = TEN_SLAVE;
            end
         end
         default: state_d = TEN_SLAVE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TEN_SLAVE;
      end else begin
         state_q <= state_d;
      end
   end

   assign is_master = (state_q == TEN_MASTER);

endmodule

// File: rtl/extbus_req_ctl.sv
module extbus_req_ctl
   import extbus_req_pkg::*;
#(
   parameter int unsigned NUM_EXT     = 4,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_req,
   input  logic               req_hold,
   input  logic               bus_grant,
   input  logic               bus_free,
   input  logic               park_en,
   output logic               breq_n,
   output logic               is_master
);

   generate
      if (NUM_EXT < 1) begin : g_bad_ext
         $error("extbus_req_ctl: NUM_EXT must be at least 1");
      end
      if (SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("extbus_req_ctl: SYNC_STAGES exceeds MAX_SYNC_STAGES");
      end
   endgenerate

   logic want;
   logic gnt_eff;
   logic free_eff;

   extbus_want_reg #(
      .NUM_EXT (NUM_EXT)
   ) u_want (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_req  (ext_req),
      .req_hold (req_hold),
      .want     (want),
      .breq_n   (breq_n)
   );

   extbus_in_sync #(
      .STAGES (SYNC_STAGES)
   ) u_gnt_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (bus_grant),
      .d_out (gnt_eff)
   );

   extbus_in_sync #(
      .STAGES (SYNC_STAGES)
   ) u_free_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (bus_free),
      .d_out (free_eff)
   );

   extbus_tenure_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .want      (want),
      .gnt       (gnt_eff),
      .free      (free_eff),
      .park_en   (park_en),
      .is_master (is_master)
   );

endmodule

// File: rtl/extbus_req_ctl_chk.sv
module extbus_req_ctl_chk #(
   parameter int unsigned NUM_EXT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EXT-1:0] ext_req,
   input logic               req_hold,
   input logic               park_en,
   input logic               gnt_eff,
   input logic               breq_n,
   input logic               is_master
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (breq_n && !is_master));

   // R2
   req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ext_req) || req_hold) |=> !breq_n);

   // R3
   req_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(breq_n));

   // R4
   hold_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_hold |=> !breq_n);

   // R5
   no_master_wo_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_master) |-> $past(gnt_eff));

   // R9
   park_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && gnt_eff && park_en) |=> is_master);

   // R11
   grant_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_master && !gnt_eff) |=> !is_master);

endmodule

bind extbus_req_ctl extbus_req_ctl_chk #(
   .NUM_EXT (NUM_EXT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_req   (ext_req),
   .req_hold  (req_hold),
   .park_en   (park_en),
   .gnt_eff   (gnt_eff),
   .breq_n    (breq_n),
   .is_master (is_master)
);

// File: tb/sim_extbus_req_ctl.sv
module sim_extbus_req_ctl;

   localparam int unsigned NEXT = 4;

   typedef struct {
      logic  breq_n;
      logic  master;
      string tag;
   } exp_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NEXT-1:0] ext_req = '0;
   logic            req_hold = 1'b0;
   logic            bus_grant = 1'b0;
   logic            bus_free = 1'b0;
   logic            park_en = 1'b0;
   logic            breq_n;
   logic            is_master;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic m_model = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;

   extbus_req_ctl #(.NUM_EXT(NEXT), .SYNC_STAGES(0)) u0 (
      .clk (clk), .rst_n (rst_n), .ext_req (ext_req), .req_hold (req_hold),
      .bus_grant (bus_grant), .bus_free (bus_free), .park_en (park_en),
      .breq_n (breq_n), .is_master (is_master)
   );

   task automatic step(input logic [NEXT-1:0] e, input logic h, input logic g,
                       input logic f, input logic p, input string tag);
      exp_t x;
      logic w;
      @(negedge clk);
      ext_req = e; req_hold = h; bus_grant = g; bus_free = f; park_en = p;
      w = (|e) | h;
      if (!m_model) m_model = g && f && w;
      else          m_model = g && (w || p);
      x.breq_n = ~w;
      x.master = m_model;
      x.tag    = tag;
      exp_q.push_back(x);
   endtask

   // monitor: one result per applied pattern, due after the next rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_cmp++;
            if (breq_n !== x.breq_n || is_master !== x.master) begin
               n_bad++;
               $display("FAIL %s: breq_n/is_master = %b/%b, expected %b/%b",
                        x.tag, breq_n, is_master, x.breq_n, x.master);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      repeat (3) @(negedge clk);
      // R1: reset values while reset held, inputs active
      ext_req = 4'b1111; bus_grant = 1'b1; bus_free = 1'b1; req_hold = 1'b1;
      @(negedge clk);
      n_cmp++;
      if (breq_n !== 1'b1 || is_master !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: breq_n/is_master = %b/%b, expected 1/0", breq_n, is_master);
      end
      ext_req = '0; bus_grant = 1'b0; req_hold = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      step(4'b0000, 0, 0, 1, 0, "R2");
      step(4'b0001, 0, 0, 1, 0, "R5");
      step(4'b0001, 0, 1, 0, 0, "R7");
      step(4'b0001, 0, 1, 1, 0, "R6");
      step(4'b0000, 0, 1, 1, 0, "R8");
      step(4'b0100, 0, 1, 1, 1, "R6");
      step(4'b0000, 0, 1, 1, 1, "R9");
      step(4'b0000, 0, 1, 0, 1, "R9");
      step(4'b0010, 0, 1, 0, 1, "R10");
      step(4'b0000, 0, 1, 1, 1, "R9");
      step(4'b0000, 0, 0, 1, 1, "R11");
      step(4'b0000, 1, 0, 1, 0, "R4");
      step(4'b0000, 1, 1, 1, 0, "R4");
      step(4'b0000, 0, 1, 1, 0, "R8");
      step(4'b1000, 0, 1, 1, 0, "R6");
      step(4'b1000, 0, 0, 1, 0, "R11");
      step(4'b1000, 0, 0, 1, 0, "R2");
      step(4'b0000, 0, 0, 1, 0, "R3");

      lf = 8'h5a;
      for (int i = 0; i < 400; i++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         step(lf[3:0] & {4{lf[7]}}, lf[6] & lf[2], lf[5] | lf[1],
              lf[4] | lf[0], lf[3], "R2");
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule